// File: doc/BRIEF.md
# Flag-Producing Integer Add Execution Unit

This unit executes one integer addition micro-operation per clock. The first addend always comes from a register operand. The second addend comes either from a second register operand or from a signed immediate. A select input chooses between the two. The operation width is 1, 2, 4 or 8 bytes. The sum is returned combinationally on the result port, truncated to the chosen width and zero-filled above it.

In the same cycle the unit derives eight condition flags from the sum at the chosen width:

- two identical carry flags
- two identical zero flags
- low-byte parity
- nibble (auxiliary) carry
- sign
- signed overflow

A per-flag write mask selects which of these are loaded into the flag register on the next rising clock edge. Flags whose mask bit is clear keep their stored value. A synchronous reset clears the flag register.

A scheduler drives one operation per cycle and supplies the write mask that the instruction being cracked requires. It reads the result in the same cycle and reads the stored flags from the following cycle onward.

Top module: `addflag_unit`

## Requirements
- R1: With `use_imm` = 0, `result` equals `src_a + src_b` at the selected width in the same cycle, with no register in the path.
- R2: With `use_imm` = 1, the second addend is `imm` sign-extended to the selected width, and `src_b` has no effect on `result`.
- R3: `size_sel` encodes the width: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 = 64 bits. Result bits above the width are 0, and operand bits above the width have no effect.
- R4: Flag bits 0 and 1 are both loaded with the carry out of the most significant bit of the selected width.
- R5: Flag bits 2 and 3 are both loaded with 1 when the truncated result is zero, and with 0 otherwise.
- R6: Flag bit 4 is loaded with 1 when `result[7:0]` holds an even number of ones.
- R7: Flag bit 5 is loaded with the carry from bit 3 into bit 4 of the addition.
- R8: Flag bit 6 is loaded with the most significant bit of the result at the selected width.
- R9: Flag bit 7 is loaded with 1 when both addends have the same sign at the selected width and the sign of the result differs from it.
- R10: On a rising edge, flag bit i is loaded only when `flag_wen[i]` is 1. Otherwise flag bit i keeps its value. The new flags appear on `flags` one cycle after the operation is presented.
- R11: A synchronous `rst` clears all eight flags at the next edge, whatever the value of `flag_wen`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high, clears the flags |
| use_imm | input | 1 | 1 selects the immediate as the second addend |
| size_sel | input | 2 | Operation width code (0: 8, 1: 16, 2: 32, 3: 64 bits) |
| src_a | input | 64 | First register operand |
| src_b | input | 64 | Second register operand |
| imm | input | 32 | Signed immediate operand |
| flag_wen | input | 8 | Per-flag write mask, bit i enables flag i |
| result | output | 64 | Truncated sum, combinational |
| flags | output | 8 | Registered flags {OF, SF, AF, PF, ZF2, ZF, CF2, CF} |

## Verification
Two functions can meet in one cycle: a flag update and the flag reset. The bench asserts `rst` while a full write mask and an operation that would set several flags are presented together, and expects all flags to read zero one cycle later.

A second collision is between partial masks and live results. Operations that change every flag are presented with sparse masks. A bit-serial reference model predicts, bit by bit, which flags must move and which must hold. Every cycle is compared against that model.

// File: rtl/addflag_pkg.sv
package addflag_pkg;

    localparam int NUM_FLAGS = 8;
    localparam int NUM_SIZES = 4;

    typedef enum logic [2:0] {
        FLG_CARRY   = 3'd0,
        FLG_CARRY_X = 3'd1,
        FLG_ZERO    = 3'd2,
        FLG_ZERO_X  = 3'd3,
        FLG_PARITY  = 3'd4,
        FLG_AUX     = 3'd5,
        FLG_SIGN    = 3'd6,
        FLG_OVFL    = 3'd7
    } flag_idx_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } opsize_e;

    // Packed most significant first, so bit 0 is the carry flag.
    typedef struct packed {
        logic ovfl;
        logic sign;
        logic aux;
        logic parity;
        logic zero_x;
        logic zero;
        logic carry_x;
        logic carry;
    } flag_vec_t;

    typedef struct packed {
        flag_vec_t flags;
    } flag_state_t;

endpackage

// File: rtl/addflag_opnd_sel.sv
module addflag_opnd_sel
    import addflag_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 32
) (
    input  logic              use_imm,
    input  opsize_e           size_sel,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] opa,
    output logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] size_mask,
    output logic [DATA_W-1:0] msb_sel
);

    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] mask_tbl [NUM_SIZES];
    logic [DATA_W-1:0] msb_tbl  [NUM_SIZES];
    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] second;

    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
        localparam int RAW_W = 8 << s;
        localparam int EFF_W = (RAW_W > DATA_W) ? DATA_W : RAW_W;
        if (EFF_W >= DATA_W) begin : g_full
            assign mask_tbl[s] = '1;
        end else begin : g_part
            assign mask_tbl[s] = {{(DATA_W-EFF_W){1'b0}}, {EFF_W{1'b1}}};
        end
        assign msb_tbl[s] = {{(DATA_W-1){1'b0}}, 1'b1} << (EFF_W - 1);
    end

    assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};

    always_comb begin
        second    = use_imm ? imm_ext : src_b;
        size_mask = mask_tbl[size_sel];
        msb_sel   = msb_tbl[size_sel];
        opa       = src_a  & size_mask;
        opb       = second & size_mask;
    end

endmodule

// File: rtl/addflag_adder.sv
module addflag_adder #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [DATA_W-1:0] size_mask,
    input  logic [DATA_W-1:0] msb_sel,
    output logic [DATA_W-1:0] sum,
    output logic              carry_out,
    output logic              nib_carry,
    output logic              sign_a,
    output logic              sign_b,
    output logic              sign_r
);

    logic [DATA_W:0] sum_full;

    always_comb begin
        sum_full  = {1'b0, opa} + {1'b0, opb};
        sum       = sum_full[DATA_W-1:0] & size_mask;
        // Operands are already masked, so the bit just above the top
        // bit of the width is the carry out of that width.
        carry_out = |(sum_full[DATA_W:1] & msb_sel);
        nib_carry = opa[4] ^ opb[4] ^ sum_full[4];
        sign_a    = |(opa & msb_sel);
        sign_b    = |(opb & msb_sel);
        sign_r    = |(sum & msb_sel);
    end

endmodule

// File: rtl/addflag_flag_calc.sv
module addflag_flag_calc
    import addflag_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] sum,
    input  logic              carry_out,
    input  logic              nib_carry,
    input  logic              sign_a,
    input  logic              sign_b,
    input  logic              sign_r,
    output flag_vec_t         fresh
);

    logic is_zero;

    always_comb begin
        is_zero       = (sum == '0);
        fresh.carry   = carry_out;
        fresh.carry_x = carry_out;
        fresh.zero    = is_zero;
        fresh.zero_x  = is_zero;
        fresh.parity  = ~^sum[7:0];
        fresh.aux     = nib_carry;
        fresh.sign    = sign_r;
        fresh.ovfl    = (sign_a == sign_b) && (sign_r != sign_a);
    end

endmodule

// File: rtl/addflag_flag_reg.sv
module addflag_flag_reg
    import addflag_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_FLAGS-1:0] wen,
    input  flag_vec_t            fresh,
    output flag_vec_t            flags_q
);

    flag_state_t st_d;
    flag_state_t st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_FLAGS; i++) begin
            if (wen[i]) begin
                st_d.flags[i] = fresh[i];
            end
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign flags_q = st_q.flags;

endmodule

// File: rtl/addflag_unit.sv
module addflag_unit
    import addflag_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 use_imm,
    input  logic [1:0]           size_sel,
    input  logic [DATA_W-1:0]    src_a,
    input  logic [DATA_W-1:0]    src_b,
    input  logic [IMM_W-1:0]     imm,
    input  logic [NUM_FLAGS-1:0] flag_wen,
    output logic [DATA_W-1:0]    result,
    output logic [NUM_FLAGS-1:0] flags
);

    opsize_e           size_e;
    logic [DATA_W-1:0] opa;
    logic [DATA_W-1:0] opb;
    logic [DATA_W-1:0] size_mask;
    logic [DATA_W-1:0] msb_sel;
    logic [DATA_W-1:0] sum;
    logic              carry_out;
    logic              nib_carry;
    logic              sign_a;
    logic              sign_b;
    logic              sign_r;
    flag_vec_t         fresh;
    flag_vec_t         flags_q;

    assign size_e = opsize_e'(size_sel);

    addflag_opnd_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_sel (
        .use_imm  (use_imm),
        .size_sel (size_e),
        .src_a    (src_a),
        .src_b    (src_b),
        .imm      (imm),
        .opa      (opa),
        .opb      (opb),
        .size_mask(size_mask),
        .msb_sel  (msb_sel)
    );

    addflag_adder #(.DATA_W(DATA_W)) u_add (
        .opa      (opa),
        .opb      (opb),
        .size_mask(size_mask),
        .msb_sel  (msb_sel),
        .sum      (sum),
        .carry_out(carry_out),
        .nib_carry(nib_carry),
        .sign_a   (sign_a),
        .sign_b   (sign_b),
        .sign_r   (sign_r)
    );

    addflag_flag_calc #(.DATA_W(DATA_W)) u_calc (
        .sum      (sum),
        .carry_out(carry_out),
        .nib_carry(nib_carry),
        .sign_a   (sign_a),
        .sign_b   (sign_b),
        .sign_r   (sign_r),
        .fresh    (fresh)
    );

    addflag_flag_reg u_freg (
        .clk    (clk),
        .rst    (rst),
        .wen    (flag_wen),
        .fresh  (fresh),
        .flags_q(flags_q)
    );

    assign result = sum;
    assign flags  = flags_q;

endmodule

// File: rtl/addflag_unit_chk.sv
module addflag_unit_chk #(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              use_imm,
    input logic [1:0]        size_sel,
    input logic [DATA_W-1:0] src_a,
    input logic [DATA_W-1:0] src_b,
    input logic [IMM_W-1:0]  imm,
    input logic [7:0]        flag_wen,
    input logic [DATA_W-1:0] result,
    input logic [7:0]        flags
);

    logic res_top;

    always_comb begin
        case (size_sel)
            2'd0:    res_top = result[7];
            2'd1:    res_top = result[15];
            2'd2:    res_top = result[31];
            default: res_top = result[DATA_W-1];
        endcase
    end

    p_reset_clears_r11: assert property (@(posedge clk)
        rst |=> (flags == 8'h00));

    for (genvar i = 0; i < 8; i++) begin : g_hold
        p_masked_hold_r10: assert property (@(posedge clk) disable iff (rst)
            !flag_wen[i] |=> (flags[i] == $past(flags[i])));
    end

    p_carry_copy_r4: assert property (@(posedge clk) disable iff (rst)
        (flag_wen[0] && flag_wen[1]) |=> (flags[0] == flags[1]));

    p_zero_r5: assert property (@(posedge clk) disable iff (rst)
        flag_wen[2] |=> (flags[2] == ($past(result) == '0)));

    p_parity_r6: assert property (@(posedge clk) disable iff (rst)
        flag_wen[4] |=> (flags[4] == ~^$past(result[7:0])));

    p_sign_r8: assert property (@(posedge clk) disable iff (rst)
        flag_wen[6] |=> (flags[6] == $past(res_top)));

    p_byte_trunc_r3: assert property (@(posedge clk) disable iff (rst)
        (size_sel == 2'd0) |-> (result[DATA_W-1:8] == '0));

endmodule

bind addflag_unit addflag_unit_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (.*);

// File: tb/addflag_unit_tb_top.sv
`timescale 1ns/1ps
module addflag_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        use_imm;
    logic [1:0]  size_sel;
    logic [63:0] src_a;
    logic [63:0] src_b;
    logic [31:0] imm;
    logic [7:0]  flag_wen;
    logic [63:0] result;
    logic [7:0]  flags;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    bit [7:0] model_flags;

    string flag_tag [8] = '{"R4", "R4", "R5", "R5", "R6", "R7", "R8", "R9"};

    always #4 clk = ~clk;

    addflag_unit dut_i (
        .clk(clk), .rst(rst), .use_imm(use_imm), .size_sel(size_sel),
        .src_a(src_a), .src_b(src_b), .imm(imm), .flag_wen(flag_wen),
        .result(result), .flags(flags)
    );

    // Bit-serial reference: ripple one bit at a time up to the width.
    function automatic void ref_add(input bit imm_f, input int sz,
                                    input bit [63:0] a, input bit [63:0] b,
                                    input bit [31:0] im,
                                    output bit [63:0] res, output bit [7:0] fl);
        int w = 8 << sz;
        bit [63:0] bop;
        bit c = 1'b0;
        bit c4 = 1'b0;
        int ones = 0;
        bop = imm_f ? {{32{im[31]}}, im} : b;
        res = '0;
        for (int k = 0; k < w; k++) begin
            if (k == 4) c4 = c;
            res[k] = a[k] ^ bop[k] ^ c;
            c = (a[k] & bop[k]) | (a[k] & c) | (bop[k] & c);
        end
        for (int k = 0; k < 8; k++) ones += int'(res[k]);
        fl[0] = c;
        fl[1] = c;
        fl[2] = (res == 64'd0);
        fl[3] = (res == 64'd0);
        fl[4] = (ones % 2 == 0);
        fl[5] = c4;
        fl[6] = res[w-1];
        fl[7] = (a[w-1] == bop[w-1]) && (res[w-1] != a[w-1]);
    endfunction

    task automatic check_flags(input bit [7:0] wen, input string why);
        for (int i = 0; i < 8; i++) begin
            n_checks++;
            if (flags[i] !== model_flags[i]) begin
                n_fail++;
                $display("FAIL %s flag%0d (%s): actual=%b expected=%b",
                         wen[i] ? flag_tag[i] : "R10", i, why, flags[i], model_flags[i]);
            end
        end
    endtask

    // Called at a negedge; returns at the following negedge.
    task automatic run_op(input bit imm_f, input int sz, input bit [63:0] a,
                          input bit [63:0] b, input bit [31:0] im,
                          input bit [7:0] wen, input string why);
        bit [63:0] eres;
        bit [7:0]  efl;
        ref_add(imm_f, sz, a, b, im, eres, efl);
        use_imm  = imm_f;
        size_sel = 2'(sz);
        src_a    = a;
        src_b    = b;
        imm      = im;
        flag_wen = wen;
        #1;
        n_checks++;
        if (result !== eres) begin
            n_fail++;
            $display("FAIL %s R3 result (%s): actual=%h expected=%h",
                     imm_f ? "R2" : "R1", why, result, eres);
        end
        for (int i = 0; i < 8; i++)
            if (wen[i]) model_flags[i] = efl[i];
        @(negedge clk);
        check_flags(wen, why);
    endtask

    initial begin
        rst = 1'b1; use_imm = 1'b0; size_sel = 2'd0;
        src_a = '0; src_b = '0; imm = '0; flag_wen = '0;
        model_flags = '0;
        @(negedge clk);
        @(negedge clk);
        check_flags(8'h00, "R11 reset state");
        rst = 1'b0;

        run_op(0, 0, 64'hFF, 64'h01, 0, 8'hFF, "byte wrap to zero");
        run_op(0, 0, 64'h7F, 64'h01, 0, 8'hFF, "byte signed overflow");
        run_op(0, 0, 64'hDEAD_BEEF_0000_1280, 64'hFFFF_0000_1111_0080, 0, 8'hFF,
               "byte with upper junk, negative overflow");
        run_op(1, 1, 64'hFFFF, 64'h1234, 32'hFFFF_FFFF, 8'hFF, "half plus imm -1");
        run_op(1, 2, 64'h0000_0000_0000_0005, 64'd0, 32'hFFFF_FFF0, 8'hFF,
               "word plus negative imm");
        run_op(1, 3, 64'h0000_0001_0000_0000, 64'hFFFF, 32'h8000_0000, 8'hFF,
               "dword imm sign extended");
        run_op(0, 3, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 8'hFF, "dword carry out");
        run_op(0, 3, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 0, 8'hFF, "dword overflow");
        run_op(0, 2, 64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000, 0, 8'hFF,
               "word neg plus neg");
        run_op(0, 0, 64'h08, 64'h08, 0, 8'hFF, "nibble carry only");

        run_op(0, 0, 64'h01, 64'h01, 0, 8'h00, "no flag written");
        run_op(0, 0, 64'hFF, 64'h01, 0, 8'h55, "even mask bits only");
        run_op(0, 1, 64'h7FFF, 64'h0001, 0, 8'hAA, "odd mask bits only");

        // Reset in the same cycle as a full flag write: reset must win.
        model_flags = '0;
        use_imm = 1'b0; size_sel = 2'd0; src_a = 64'hFF; src_b = 64'h01;
        flag_wen = 8'hFF; rst = 1'b1;
        @(negedge clk);
        check_flags(8'h00, "R11 reset beats write");
        rst = 1'b0;

        for (int n = 0; n < 400; n++) begin
            run_op($urandom_range(0, 1), $urandom_range(0, 3),
                   {$urandom, $urandom}, {$urandom, $urandom}, $urandom,
                   8'($urandom), "random");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        done = 1'b1;
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule